// File: doc/BRIEF.md
# Character Overlay Display Generator

This block draws a text overlay on a video raster. A CPU loads a grid of 6 rows by 20 columns of 8-bit character codes, a 3-bit colour for each row and a handful of layout settings through a simple write port. During active video the block counts dots and lines from the sync inputs. It finds the character cell under the current dot and computes that character's dot pattern. It then drives red, green and blue levels together with a blank signal that keys the overlay over the picture.

Colour is chosen per row, not per character. One selectable row can be split at a programmable column into two colours, which suits bar indicators such as a volume gauge. Characters are drawn either as small 5x7 glyphs in 8x8 cells or as large 11x15 glyphs in 16x16 cells. Around each horizontal sync the dot count is frozen and then restarted at a fixed delay, so every line begins counting at the same place. All CPU writes go to a staging copy that is moved into the displayed copy at the start of a frame.

Top module: `osd_overlay`

## Requirements
- R1: While reset is asserted and after it is released, blank and all colour outputs stay low, and every cell holds the space code 0x20 until the first frame boundary after something else is written.
- R2: The dot counter restarts at dot 0 on the third clock edge that samples hsync low after a high period of any length. The pixel for dot k appears on the outputs after the (k+4)th such edge.
- R3: Once hsync has been sampled high on two consecutive edges, the dot counter stops. From the third edge of the pulse onward, blank stays low while hsync is high.
- R4: The line counter is cleared while vsync is high and increments by one on every rising edge of hsync.
- R5: Blank can be high only inside the window that starts at dot hstart (register 128) and line vstart (register 129) and spans 20 cells across and 6 cells down.
- R6: In low-resolution mode (register 131 bit 0 = 0), cells are 8 dots by 8 lines, and only dots 0..4 of lines 0..6 of a cell can be lit.
- R7: In high-resolution mode (register 131 bit 0 = 1), cells are 16 dots by 16 lines, and only dots 0..10 of lines 0..14 of a cell can be lit.
- R8: The dot pattern for code c on cell line y is the 11-bit value {c[2:0],c} XOR {y[2:0],y,y}, where y is 4 bits, masked to its low 5 bits in low-resolution mode. Its most significant used bit is the leftmost dot.
- R9: A cell holding code 0x20 never raises blank.
- R10: A lit dot takes its row's 3-bit colour (registers 120..125, one per row; bit 2 red, bit 1 green, bit 0 blue). Red, green and blue are low whenever blank is low.
- R11: In the bar row (register 126, 3 bits; 6 or 7 selects none), columns at or beyond the split column (register 127, 5 bits) use the bar colour (register 130) instead of the row colour.
- R12: Writes change only the staging copy. The displayed copy takes all staged values at once on a rising edge of vsync, so a frame in progress never changes.
- R13: Register addresses 0..119 hold character codes at row*20+column. Writes to addresses above 131 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dot-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync | input | 1 | Horizontal sync, active high |
| vsync | input | 1 | Vertical sync, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register address |
| wr_data | input | 8 | Register write data |
| vred | output | 1 | Red overlay level |
| vgreen | output | 1 | Green overlay level |
| vblue | output | 1 | Blue overlay level |
| vblank | output | 1 | Overlay key, high on lit dots |

## Verification
A dot counter that is off by even one cycle after hsync shifts every glyph sideways. The whole line then disagrees with the expected picture from the first lit dot, one line after the fault. A wrong line count or cell lookup shows up as glyph rows or colours that belong to a different cell, and this is visible within a single character height. A commit that leaks early shows the changed content on the lines drawn right after a mid-frame write, instead of one frame later. A run gate that fails to stop shows lit dots while hsync is held high.

// File: rtl/osd_pkg.sv
package osd_pkg;
    localparam int DEF_ROWS    = 6;
    localparam int DEF_COLS    = 20;
    localparam int CODE_W      = 8;
    localparam int RGB_W       = 3;
    localparam int ADDR_W      = 8;
    localparam int GLYPH_W     = 11;
    localparam int GLYPH_LO_W  = 5;
    localparam int CELL_LINE_W = 4;
    localparam logic [CODE_W-1:0] SPACE_CODE = 8'h20;

    typedef struct packed {
        logic [7:0]       hstart;
        logic [7:0]       vstart;
        logic [2:0]       bar_row;
        logic [4:0]       split;
        logic [RGB_W-1:0] bar_rgb;
        logic             hires;
    } osd_cfg_t;
endpackage

// File: rtl/osd_regfile.sv
module osd_regfile
    import osd_pkg::*;
#(
    parameter int ROWS = DEF_ROWS,
    parameter int COLS = DEF_COLS
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              vsync,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 wr_addr,
    input  logic [7:0]                        wr_data,
    output logic [ROWS*COLS-1:0][CODE_W-1:0]  act_ch,
    output logic [ROWS-1:0][RGB_W-1:0]        act_rgb,
    output osd_cfg_t                          act_cfg
);
    localparam int CELLS   = ROWS * COLS;
    localparam int A_RGB0  = CELLS;
    localparam int A_BAR   = CELLS + ROWS;
    localparam int A_SPLIT = A_BAR + 1;
    localparam int A_HST   = A_BAR + 2;
    localparam int A_VST   = A_BAR + 3;
    localparam int A_BRGB  = A_BAR + 4;
    localparam int A_MODE  = A_BAR + 5;

    typedef struct packed {
        logic [CELLS-1:0][CODE_W-1:0] sh_ch;
        logic [CELLS-1:0][CODE_W-1:0] ac_ch;
        logic [ROWS-1:0][RGB_W-1:0]   sh_rgb;
        logic [ROWS-1:0][RGB_W-1:0]   ac_rgb;
        osd_cfg_t                     sh_cfg;
        osd_cfg_t                     ac_cfg;
        logic                         vs;
    } rf_t;

    rf_t rf_q, rf_d;
    logic frame_edge;

    always_comb begin
        rf_d       = rf_q;
        rf_d.vs    = vsync;
        frame_edge = vsync && !rf_q.vs;
        if (frame_edge) begin
            rf_d.ac_ch  = rf_q.sh_ch;
            rf_d.ac_rgb = rf_q.sh_rgb;
            rf_d.ac_cfg = rf_q.sh_cfg;
        end
        if (wr_en) begin
            for (int i = 0; i < CELLS; i++) begin
                if (wr_addr == ADDR_W'(i)) rf_d.sh_ch[i] = wr_data;
            end
            for (int r = 0; r < ROWS; r++) begin
                if (wr_addr == ADDR_W'(A_RGB0 + r)) rf_d.sh_rgb[r] = wr_data[RGB_W-1:0];
            end
            if (wr_addr == ADDR_W'(A_BAR))   rf_d.sh_cfg.bar_row = wr_data[2:0];
            if (wr_addr == ADDR_W'(A_SPLIT)) rf_d.sh_cfg.split   = wr_data[4:0];
            if (wr_addr == ADDR_W'(A_HST))   rf_d.sh_cfg.hstart  = wr_data;
            if (wr_addr == ADDR_W'(A_VST))   rf_d.sh_cfg.vstart  = wr_data;
            if (wr_addr == ADDR_W'(A_BRGB))  rf_d.sh_cfg.bar_rgb = wr_data[RGB_W-1:0];
            if (wr_addr == ADDR_W'(A_MODE))  rf_d.sh_cfg.hires   = wr_data[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rf_q                <= '0;
            rf_q.sh_ch          <= {CELLS{SPACE_CODE}};
            rf_q.ac_ch          <= {CELLS{SPACE_CODE}};
            rf_q.sh_cfg.bar_row <= 3'd7;
            rf_q.ac_cfg.bar_row <= 3'd7;
        end else begin
            rf_q <= rf_d;
        end
    end

    assign act_ch  = rf_q.ac_ch;
    assign act_rgb = rf_q.ac_rgb;
    assign act_cfg = rf_q.ac_cfg;

    AST_SHOWN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(vsync && !rf_q.vs) |=> ($stable(rf_q.ac_ch) && $stable(rf_q.ac_rgb) && $stable(rf_q.ac_cfg))); // R12
    AST_COMMIT_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
        (vsync && !rf_q.vs) |=> (rf_q.ac_cfg == $past(rf_q.sh_cfg))); // R12
endmodule

// File: rtl/osd_timing.sv
module osd_timing #(
    parameter int STOP_DLY  = 2,
    parameter int START_DLY = 3,
    parameter int COORD_W   = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hsync,
    input  logic               vsync,
    output logic               run,
    output logic [COORD_W-1:0] dot_x,
    output logic [COORD_W-1:0] line
);
    localparam int HI_W = $clog2(STOP_DLY + 1);
    localparam int LO_W = $clog2(START_DLY + 1);

    typedef struct packed {
        logic [HI_W-1:0]    hi;
        logic [LO_W-1:0]    lo;
        logic               run;
        logic               hs;
        logic [COORD_W-1:0] dot;
        logic [COORD_W-1:0] line;
    } tm_t;

    tm_t tm_q, tm_d;

    always_comb begin
        tm_d    = tm_q;
        tm_d.hs = hsync;
        if (tm_q.run && tm_q.dot != '1) tm_d.dot = tm_q.dot + 1'b1;
        if (hsync) begin
            tm_d.lo = '0;
            if (tm_q.hi != HI_W'(STOP_DLY)) tm_d.hi = tm_q.hi + 1'b1;
            if (tm_q.hi == HI_W'(STOP_DLY - 1)) tm_d.run = 1'b0;
        end else begin
            tm_d.hi = '0;
            if (tm_q.lo != LO_W'(START_DLY)) tm_d.lo = tm_q.lo + 1'b1;
            if (tm_q.lo == LO_W'(START_DLY - 1)) begin
                tm_d.run = 1'b1;
                tm_d.dot = '0;
            end
        end
        if (vsync) begin
            tm_d.line = '0;
        end else if (hsync && !tm_q.hs && tm_q.line != '1) begin
            tm_d.line = tm_q.line + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tm_q     <= '0;
            tm_q.dot <= '1;
        end else begin
            tm_q <= tm_d;
        end
    end

    assign run   = tm_q.run;
    assign dot_x = tm_q.dot;
    assign line  = tm_q.line;

    AST_STOP_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tm_q.run) |-> ($past(hsync, 1) && $past(hsync, 2))); // R3
    AST_FROZEN_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !tm_q.run |=> ($stable(tm_q.dot) || tm_q.dot == '0)); // R3
    AST_RESTART_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tm_q.run) |-> (tm_q.dot == '0 && !$past(hsync))); // R2
    AST_LINE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        vsync |=> tm_q.line == '0); // R4
endmodule

// File: rtl/osd_glyph.sv
module osd_glyph
    import osd_pkg::*;
#(
    parameter int GW   = GLYPH_W,
    parameter int LW   = CELL_LINE_W,
    parameter int LO_W = GLYPH_LO_W
) (
    input  logic [CODE_W-1:0] code,
    input  logic [LW-1:0]     cy,
    input  logic              hires,
    output logic [GW-1:0]     dots
);
    logic [GW-1:0] raw;

    always_comb begin
        raw  = GW'({code, code}) ^ GW'({cy, cy, cy});
        dots = hires ? raw : (raw & GW'((1 << LO_W) - 1));
    end
endmodule

// File: rtl/osd_overlay.sv
module osd_overlay
    import osd_pkg::*;
#(
    parameter int ROWS      = DEF_ROWS,
    parameter int COLS      = DEF_COLS,
    parameter int STOP_DLY  = 2,
    parameter int START_DLY = 3,
    parameter int COORD_W   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsync,
    input  logic              vsync,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              vred,
    output logic              vgreen,
    output logic              vblue,
    output logic              vblank
);
    localparam int CELLS = ROWS * COLS;

    typedef struct packed {
        logic             blank;
        logic [RGB_W-1:0] rgb;
    } pix_t;

    logic [CELLS-1:0][CODE_W-1:0] act_ch;
    logic [ROWS-1:0][RGB_W-1:0]   act_rgb;
    osd_cfg_t                     cfg;
    logic                         run;
    logic [COORD_W-1:0]           dot_x, line;

    osd_regfile #(.ROWS(ROWS), .COLS(COLS)) u_regs (
        .clk(clk), .rst_n(rst_n), .vsync(vsync), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .act_ch(act_ch), .act_rgb(act_rgb), .act_cfg(cfg)
    );

    osd_timing #(.STOP_DLY(STOP_DLY), .START_DLY(START_DLY), .COORD_W(COORD_W)) u_timing (
        .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
        .run(run), .dot_x(dot_x), .line(line)
    );

    logic [COORD_W-1:0]     rx, ry, col, row;
    logic [CELL_LINE_W-1:0] cx, cy, gw, gh, bit_idx;
    logic                   in_win, lit_bit;
    logic [CODE_W-1:0]      code;
    logic [RGB_W-1:0]       colour;
    logic [GLYPH_W-1:0]     dots;
    pix_t                   pix_q, pix_d;

    always_comb begin
        rx  = dot_x - COORD_W'(cfg.hstart);
        ry  = line - COORD_W'(cfg.vstart);
        col = cfg.hires ? (rx >> 4) : (rx >> 3);
        row = cfg.hires ? (ry >> 4) : (ry >> 3);
        cx  = cfg.hires ? rx[3:0] : {1'b0, rx[2:0]};
        cy  = cfg.hires ? ry[3:0] : {1'b0, ry[2:0]};
        gw  = cfg.hires ? CELL_LINE_W'(11) : CELL_LINE_W'(5);
        gh  = cfg.hires ? CELL_LINE_W'(15) : CELL_LINE_W'(7);
        in_win = run && (dot_x >= COORD_W'(cfg.hstart)) && (line >= COORD_W'(cfg.vstart))
                 && (col < COORD_W'(COLS)) && (row < COORD_W'(ROWS));
        code   = SPACE_CODE;
        colour = '0;
        for (int r = 0; r < ROWS; r++) begin
            if (row == COORD_W'(r)) colour = act_rgb[r];
            for (int c = 0; c < COLS; c++) begin
                if (row == COORD_W'(r) && col == COORD_W'(c)) code = act_ch[r*COLS + c];
            end
        end
        if (row == COORD_W'(cfg.bar_row) && col >= COORD_W'(cfg.split)) colour = cfg.bar_rgb;
    end

    osd_glyph u_glyph (.code(code), .cy(cy), .hires(cfg.hires), .dots(dots));

    always_comb begin
        bit_idx = gw - cx - 1'b1;
        lit_bit = 1'b0;
        for (int b = 0; b < GLYPH_W; b++) begin
            if (bit_idx == CELL_LINE_W'(b)) lit_bit = dots[b];
        end
        pix_d.blank = in_win && (code != SPACE_CODE) && (cx < gw) && (cy < gh) && lit_bit;
        pix_d.rgb   = pix_d.blank ? colour : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pix_q <= '0;
        else        pix_q <= pix_d;
    end

    assign vblank = pix_q.blank;
    assign vred   = pix_q.rgb[2];
    assign vgreen = pix_q.rgb[1];
    assign vblue  = pix_q.rgb[0];

    AST_DARK_WHEN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_q.blank |-> pix_q.rgb == '0); // R10
    AST_LIT_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        pix_q.blank |-> $past(run)); // R3
    AST_LIT_INSIDE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        pix_q.blank |-> ($past(line) >= COORD_W'($past(cfg.vstart))
                         && $past(dot_x) >= COORD_W'($past(cfg.hstart)))); // R5
endmodule

// File: tb/osd_overlay_bench.sv
module osd_overlay_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    logic rst_n, hsync, vsync, wr_en;
    logic [7:0] wr_addr, wr_data;
    logic vred, vgreen, vblue, vblank;

    osd_overlay u_osd_overlay (
        .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .vred(vred), .vgreen(vgreen), .vblue(vblue), .vblank(vblank)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, errors = 0, cyc = 0, lcnt = 0, lit_seen = 0;
    bit done = 0;

    logic [7:0] sh_ch [120], ac_ch [120];
    logic [2:0] sh_rgb [6], ac_rgb [6];
    int sh_hs, sh_vs, sh_bar, sh_split, sh_brgb, sh_hi;
    int ac_hs, ac_vs, ac_bar, ac_split, ac_brgb, ac_hi;

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !done) begin
            errors++;
            $display("FAIL watchdog all requirements: cycles %0d expected below %0d", cyc, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [10:0] glyph(input logic [7:0] c, input logic [3:0] y, input bit hi);
        logic [10:0] g;
        g = {c[2:0], c} ^ {y[2:0], y, y};
        if (!hi) g = g & 11'h01F;
        return g;
    endfunction

    function automatic logic [3:0] exp_px(input int ln, input int x);
        int shf, msk, rx, ry, col, row, cx, cy, gw, gh;
        logic [7:0] code;
        logic [10:0] g;
        shf = ac_hi ? 4 : 3;
        msk = ac_hi ? 15 : 7;
        gw  = ac_hi ? 11 : 5;
        gh  = ac_hi ? 15 : 7;
        if (x < ac_hs || ln < ac_vs) return 4'h0;
        rx = x - ac_hs; ry = ln - ac_vs;
        col = rx >> shf; row = ry >> shf;
        if (col >= 20 || row >= 6) return 4'h0;
        cx = rx & msk; cy = ry & msk;
        code = ac_ch[row*20 + col];
        if (code == 8'h20) return 4'h0;
        if (cx >= gw || cy >= gh) return 4'h0;
        g = glyph(code, 4'(cy), ac_hi != 0);
        if (!g[gw-1-cx]) return 4'h0;
        if (row == ac_bar && col >= ac_split) return {1'b1, 3'(ac_brgb)};
        return {1'b1, ac_rgb[row]};
    endfunction

    task automatic check(input bit ok, input string what, input int got, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", what, got, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        wr_addr = 8'(a); wr_data = 8'(d); wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        if (a < 120) sh_ch[a] = 8'(d);
        else if (a < 126) sh_rgb[a-120] = 3'(d);
        else if (a == 126) sh_bar = d & 7;
        else if (a == 127) sh_split = d & 31;
        else if (a == 128) sh_hs = d & 255;
        else if (a == 129) sh_vs = d & 255;
        else if (a == 130) sh_brgb = d & 7;
        else if (a == 131) sh_hi = d & 1;
    endtask

    task automatic vpulse();
        vsync = 1'b1;
        repeat (2) @(negedge clk);
        vsync = 1'b0;
        for (int i = 0; i < 120; i++) ac_ch[i] = sh_ch[i];
        for (int i = 0; i < 6; i++) ac_rgb[i] = sh_rgb[i];
        ac_hs = sh_hs; ac_vs = sh_vs; ac_bar = sh_bar;
        ac_split = sh_split; ac_brgb = sh_brgb; ac_hi = sh_hi;
        lcnt = 0;
    endtask

    // hsync pulse of w cycles; with chk, blank must be low from the third edge on (R3)
    task automatic hpulse(input int w, input bit chk);
        hsync = 1'b1;
        for (int j = 0; j < w; j++) begin
            @(posedge clk);
            @(negedge clk);
            if (chk && j >= 2)
                check(vblank == 1'b0, "R3 blank while dot clock held", int'(vblank), 0);
        end
        hsync = 1'b0;
        lcnt++;
    endtask

    task automatic draw(input int nx, input string tag, input int upto);
        int bad_x, bad_got, bad_exp;
        logic [3:0] got, exp;
        bad_x = -1; bad_got = 0; bad_exp = 0;
        for (int c = 0; c < upto + 3; c++) begin
            @(posedge clk);
            @(negedge clk);
            if (c >= 3 && c - 3 < nx) begin
                got = {vblank, vred, vgreen, vblue};
                exp = exp_px(lcnt, c - 3);
                if (got[3]) lit_seen++;
                if (got !== exp && bad_x < 0) begin
                    bad_x = c - 3; bad_got = int'(got); bad_exp = int'(exp);
                end
            end
        end
        checks++;
        if (bad_x >= 0) begin
            errors++;
            $display("FAIL %s line %0d dot %0d: got %0h expected %0h", tag, lcnt, bad_x, bad_got, bad_exp);
        end
    endtask

    task automatic frame(input bit do_vs, input int w, input int nl, input string tag,
                         input int midline, input int cutline);
        int nx;
        if (do_vs) vpulse();
        nx = ac_hs + 20 * (ac_hi ? 16 : 8) + 3;
        for (int i = 0; i < nl; i++) begin
            hpulse(w, 1'b0);
            if (i == cutline) begin
                draw(nx, tag, nx / 2);
                hpulse(6, 1'b1);
            end
            draw(nx, tag, nx);
            if (i == midline) begin
                // staged changes mid-frame must not show until the next vsync (R12)
                for (int k = 0; k < 120; k++) if (k % 5 == 1) wr(k, int'(sh_ch[k]) ^ 8'h5A);
                for (int r = 0; r < 6; r++) wr(120 + r, 7 - r);
                wr(126, 4); wr(127, 0); wr(128, 9); wr(129, 4); wr(130, 1);
            end
        end
    endtask

    initial begin
        rst_n = 1'b0; hsync = 1'b0; vsync = 1'b0;
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        for (int i = 0; i < 120; i++) begin sh_ch[i] = 8'h20; ac_ch[i] = 8'h20; end
        for (int i = 0; i < 6; i++) begin sh_rgb[i] = 3'd0; ac_rgb[i] = 3'd0; end
        sh_hs = 0; sh_vs = 0; sh_bar = 7; sh_split = 0; sh_brgb = 0; sh_hi = 0;
        ac_hs = 0; ac_vs = 0; ac_bar = 7; ac_split = 0; ac_brgb = 0; ac_hi = 0;

        repeat (3) begin
            @(negedge clk);
            check({vblank, vred, vgreen, vblue} == 4'h0, "R1 outputs in reset",
                  int'({vblank, vred, vgreen, vblue}), 0);
        end
        rst_n = 1'b1;
        repeat (5) begin
            @(negedge clk);
            check({vblank, vred, vgreen, vblue} == 4'h0, "R1 outputs after reset",
                  int'({vblank, vred, vgreen, vblue}), 0);
        end

        // R1: frame right after reset shows only spaces
        frame(1'b1, 4, 20, "R1 R9 empty after reset", -1, -1);

        // content A, low resolution
        for (int i = 0; i < 120; i++) wr(i, (i % 7 == 0) ? 8'h20 : ((8'h41 + 3 * i) & 255));
        for (int r = 0; r < 6; r++) wr(120 + r, r + 1);
        wr(126, 2); wr(127, 7); wr(128, 5); wr(129, 3); wr(130, 7); wr(131, 0);

        // R12: without a vsync nothing staged may appear
        lit_seen = 0;
        frame(1'b0, 4, 12, "R12 staged not shown", -1, -1);
        check(lit_seen == 0, "R12 lit dots before commit", lit_seen, 0);

        lit_seen = 0;
        frame(1'b1, 4, 3 + 48 + 2, "R4 R5 R6 R8 R9 R10 R11 R13 lowres", -1, -1);
        check(lit_seen > 0, "R6 lowres frame lit dots", lit_seen, 1);

        // one-cycle hsync pulses plus mid-frame staging (R2, R12)
        frame(1'b1, 1, 3 + 48 + 2, "R2 R12 short pulse and mid-frame write", 10, -1);

        // R13: an unmapped address changes nothing
        wr(200, 8'hFF);
        frame(1'b1, 6, 4 + 48 + 2, "R2 R11 R13 long pulse new content", -1, 20);

        // content C, high resolution
        for (int i = 0; i < 120; i++) wr(i, (i % 9 == 4) ? 8'h20 : ((8'h30 + 5 * i) & 255));
        for (int r = 0; r < 6; r++) wr(120 + r, (r * 3 + 2) & 7);
        wr(126, 5); wr(127, 19); wr(128, 2); wr(129, 1); wr(130, 3); wr(131, 1);
        lit_seen = 0;
        frame(1'b1, 3, 1 + 96 + 2, "R7 R8 R10 R11 hires", -1, 30);
        check(lit_seen > 0, "R7 hires frame lit dots", lit_seen, 1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule